// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between the on-time controller of a synchronous buck stage and its two analog gate drivers. It turns a single PWM request into separate enables for the high-side and low-side switches. It waits for sensed gate voltages before letting the complementary switch turn on, so the two switches never conduct together. The dead time therefore tracks the real gate discharge instead of a fixed worst-case delay.

At light load the block can run in diode emulation. In that mode a zero-crossing flag from the phase comparator switches off the low-side, which then stays off until the next PWM falling edge. A forced-continuous select disables this behaviour. A fixed number of cycles after each low-side turn-on, the block emits a one-cycle strobe that tells the over-current comparator when to sample. A tri-state request from the fault logic overrides everything. If a gate sense flag never arrives, a watchdog count forces the pending transition.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: After `pwm_i` is high at a clock edge, `hs_en_o` rises only after a later edge at which `ls_gate_low_i` is high, unless the R9 timeout fires first.
- R2: After `pwm_i` is low at a clock edge, `ls_en_o` rises only after a later edge at which `hs_gate_low_i` is high, unless the R9 timeout fires first.
- R3: `hs_en_o` and `ls_en_o` are never high in the same cycle. Each enable rises only in a cycle whose previous cycle had the other enable low.
- R4: With `force_ccm_i` low, a clock edge at which `zero_cross_i` is high while the low-side is on or waiting to turn on leaves `ls_en_o` low after that edge.
- R5: After a zero-crossing turn-off, `ls_en_o` stays low through the following high pulse of `pwm_i`. It may turn on again only after the next PWM falling edge.
- R6: With `force_ccm_i` high, `zero_cross_i` has no effect, and `ls_en_o` stays high for the whole PWM low interval.
- R7: `oc_sample_o` pulses high for exactly one cycle, OC_DELAY cycles after the cycle in which `ls_en_o` rose. No pulse is produced if the low-side turns off before then. The strobe is never high while `ls_en_o` is low.
- R8: While `tristate_i` is high, all three outputs are low in the same cycle, with no clock edge needed. The sequencer returns to idle and, after release, waits for `pwm_i` high before any switch turns on.
- R9: If a sense flag never arrives, the pending switch turns on after WAIT_TIMEOUT cycles in the wait state.
- R10: After reset, all outputs are low and remain low while `pwm_i` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM request, high means high-side on-time |
| force_ccm_i | input | 1 | 1 = continuous conduction, 0 = diode emulation |
| zero_cross_i | input | 1 | Inductor current about to reverse |
| ls_gate_low_i | input | 1 | Low-side gate below threshold |
| hs_gate_low_i | input | 1 | High-side gate-to-phase below threshold |
| tristate_i | input | 1 | Fault request, forces both switches off |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| oc_sample_o | output | 1 | Over-current sample strobe |

## Verification
On every cycle, the assertions check the following:
- the two enables never overlap, and each rise is preceded by a cycle with the other enable low;
- a tri-state request clears all outputs in the same cycle;
- a zero crossing in diode emulation drops the low-side at the next edge;
- the high-side rises only after a PWM-high edge;
- the strobe never appears without the low-side on.

Some behaviours need the bench scenarios, because they depend on cycle counts and on history across PWM periods:
- the adaptive waits that stretch with late sense flags;
- the exact watchdog and strobe timing;
- the suppressed strobe on an early low-side exit;
- the hold-off until the next PWM falling edge;
- the insensitivity to zero crossing in forced-continuous mode.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4,
    ST_LS_HOLD = 3'd5
  } dtg_state_e;
endpackage

// File: rtl/dtg_cycle_timer.sv
module dtg_cycle_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic hit_o
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  // saturates one past LIMIT so hit_o is a single cycle per run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (run_i && cnt_q <= LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == LIM);
endmodule

// File: rtl/dtg_sequencer.sv
module dtg_sequencer
  import dtg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwm_i,
  input  logic       force_ccm_i,
  input  logic       zero_cross_i,
  input  logic       ls_gate_low_i,
  input  logic       hs_gate_low_i,
  input  logic       tristate_i,
  input  logic       wait_hit_i,
  output dtg_state_e state_q_o,
  output logic       restart_o
);
  dtg_state_e state_q, state_d;
  logic zc_cut;

  assign zc_cut = ~force_ccm_i & zero_cross_i;

  always_comb begin
    state_d = state_q;
    if (tristate_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:    if (pwm_i) state_d = ST_HS_WAIT;
        ST_HS_WAIT: begin
          if (!pwm_i)                          state_d = ST_LS_WAIT;
          else if (ls_gate_low_i || wait_hit_i) state_d = ST_HS_ON;
        end
        ST_HS_ON:   if (!pwm_i) state_d = ST_LS_WAIT;
        ST_LS_WAIT: begin
          if (pwm_i)                           state_d = ST_HS_WAIT;
          else if (zc_cut)                     state_d = ST_LS_HOLD;
          else if (hs_gate_low_i || wait_hit_i) state_d = ST_LS_ON;
        end
        ST_LS_ON: begin
          if (pwm_i)       state_d = ST_HS_WAIT;
          else if (zc_cut) state_d = ST_LS_HOLD;
        end
        ST_LS_HOLD: if (pwm_i) state_d = ST_HS_WAIT;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign restart_o = (state_d != state_q);
endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl
  import dtg_pkg::*;
#(
  parameter int WAIT_TIMEOUT = 16,
  parameter int OC_DELAY     = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic force_ccm_i,
  input  logic zero_cross_i,
  input  logic ls_gate_low_i,
  input  logic hs_gate_low_i,
  input  logic tristate_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic oc_sample_o
);
  localparam int WAIT_LIMIT = WAIT_TIMEOUT - 1;

  dtg_state_e state_q;
  logic restart, wait_hit, oc_hit, waiting, ls_on;

  assign waiting = (state_q == ST_HS_WAIT) || (state_q == ST_LS_WAIT);
  assign ls_on   = (state_q == ST_LS_ON);

  dtg_sequencer u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwm_i         (pwm_i),
    .force_ccm_i   (force_ccm_i),
    .zero_cross_i  (zero_cross_i),
    .ls_gate_low_i (ls_gate_low_i),
    .hs_gate_low_i (hs_gate_low_i),
    .tristate_i    (tristate_i),
    .wait_hit_i    (wait_hit),
    .state_q_o     (state_q),
    .restart_o     (restart)
  );

  dtg_cycle_timer #(.LIMIT(WAIT_LIMIT)) u_wait_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (waiting),
    .hit_o     (wait_hit)
  );

  dtg_cycle_timer #(.LIMIT(OC_DELAY)) u_oc_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (ls_on),
    .hit_o     (oc_hit)
  );

  // tri-state gates the outputs combinationally, ahead of the state update
  assign hs_en_o     = (state_q == ST_HS_ON) & ~tristate_i;
  assign ls_en_o     = ls_on & ~tristate_i;
  assign oc_sample_o = oc_hit & ls_on & ~tristate_i;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic force_ccm_i,
  input logic zero_cross_i,
  input logic ls_gate_low_i,
  input logic hs_gate_low_i,
  input logic tristate_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic oc_sample_o
);
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o)); // R3

  AST_HS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> !$past(ls_en_o)); // R3

  AST_LS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(hs_en_o)); // R3

  AST_HS_AFTER_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(pwm_i)); // R1

  AST_ZC_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_ccm_i && zero_cross_i && ls_en_o) |=> !ls_en_o); // R4

  AST_STROBE_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_sample_o |-> ls_en_o); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_sample_o |=> !oc_sample_o); // R7

  always_comb begin
    if (rst_ni && tristate_i)
      AST_TRISTATE_OFF: assert (!hs_en_o && !ls_en_o && !oc_sample_o); // R8
  end
endmodule

bind deadtime_gate_ctrl dtg_checker u_chk (.*);

// File: tb/deadtime_gate_ctrl_test.sv
module deadtime_gate_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm_s = 0, ccm_s = 1, zc_s = 0, lsl_s = 0, hsl_s = 0, trs_s = 0;
  logic hs_en, ls_en, oc_smp;
  int checks = 0, errors = 0;

  typedef struct {
    logic hs;
    logic ls;
    logic oc;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  deadtime_gate_ctrl #(.WAIT_TIMEOUT(6), .OC_DELAY(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm_s), .force_ccm_i(ccm_s),
    .zero_cross_i(zc_s), .ls_gate_low_i(lsl_s), .hs_gate_low_i(hsl_s),
    .tristate_i(trs_s), .hs_en_o(hs_en), .ls_en_o(ls_en), .oc_sample_o(oc_smp)
  );

  task automatic chk(input logic h, input logic l, input logic o, input string tag);
    checks++;
    if ({hs_en, ls_en, oc_smp} !== {h, l, o}) begin
      errors++;
      $display("FAIL %s: hs/ls/oc actual %b%b%b expected %b%b%b", tag,
               hs_en, ls_en, oc_smp, h, l, o);
    end
  endtask

  // driver: one clock edge, expected outputs after it go to the scoreboard
  task automatic cyc(input logic h, input logic l, input logic o, input string tag);
    exp_t e;
    @(posedge clk);
    e.hs = h; e.ls = l; e.oc = o; e.tag = tag;
    exp_q.push_back(e);
    #5;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.hs, e.ls, e.oc, e.tag);
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #45 rst_ni = 1'b1;
    chk(0, 0, 0, "R10 reset");
    cyc(0, 0, 0, "R10 idle");
    cyc(0, 0, 0, "R10 idle");

    // adaptive wait on both sides, continuous mode
    pwm_s = 1;
    cyc(0, 0, 0, "R1 wait");
    cyc(0, 0, 0, "R1 wait");
    cyc(0, 0, 0, "R1 wait");
    lsl_s = 1;
    cyc(1, 0, 0, "R1 hs on");
    pwm_s = 0; lsl_s = 0;
    cyc(0, 0, 0, "R2 wait");
    cyc(0, 0, 0, "R2 wait");
    cyc(0, 0, 0, "R2 wait");
    hsl_s = 1;
    cyc(0, 1, 0, "R2 ls on");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R7 before strobe");
    cyc(0, 1, 1, "R7 strobe");
    cyc(0, 1, 0, "R7 after strobe");

    zc_s = 1;
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R6 zc ignored");
    zc_s = 0;

    // diode emulation
    ccm_s = 0; zc_s = 1;
    cyc(0, 0, 0, "R4 zc cut");
    zc_s = 0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R5 hold off");
    pwm_s = 1; lsl_s = 1;
    cyc(0, 0, 0, "R5 hs wait");
    cyc(1, 0, 0, "R5 hs on");
    pwm_s = 0; lsl_s = 0;
    cyc(0, 0, 0, "R5 ls wait");
    cyc(0, 1, 0, "R5 ls again");

    // early low-side exit: no strobe; then watchdog on high side
    cyc(0, 1, 0, "R7 early");
    pwm_s = 1;
    cyc(0, 0, 0, "R7 no strobe");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, "R9 hs timeout wait");
    cyc(1, 0, 0, "R9 hs forced");
    pwm_s = 0; hsl_s = 0;
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, "R9 ls timeout wait");
    cyc(0, 1, 0, "R9 ls forced");

    // zero crossing while waiting for low-side
    pwm_s = 1; lsl_s = 1;
    cyc(0, 0, 0, "R4 hs wait");
    cyc(1, 0, 0, "R4 hs on");
    pwm_s = 0; zc_s = 1;
    cyc(0, 0, 0, "R4 ls wait");
    cyc(0, 0, 0, "R4 zc in wait");
    zc_s = 0; hsl_s = 1;
    cyc(0, 0, 0, "R4 held");

    // tri-state override
    ccm_s = 1; pwm_s = 1;
    cyc(0, 0, 0, "R8 hs wait");
    cyc(1, 0, 0, "R8 hs on");
    trs_s = 1;
    #1 chk(0, 0, 0, "R8 immediate");
    cyc(0, 0, 0, "R8 idle");
    cyc(0, 0, 0, "R8 held idle");
    trs_s = 0;
    cyc(0, 0, 0, "R8 restart wait");
    cyc(1, 0, 0, "R8 restart on");
    pwm_s = 0;
    cyc(0, 0, 0, "R3 gap");
    cyc(0, 1, 0, "R3 ls on");

    @(posedge clk);
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule